// File: doc/BRIEF.md
# I2S Stereo Transmitter with Low-Water Interrupts

This block is a clock-master I2S audio transmitter. Samples arrive over a valid/ready stream and wait in a deep sample queue. The serializer takes them out two at a time, left channel first, and shifts them out on the bit clock, word-select and serial-data pins. Software programs the block through a small register port. That port holds a configuration word and a status word with sticky interrupt causes. The queue fill level cannot be read. Software learns that it must refill only from two causes: the queue has dropped under a programmable low-water mark, or the serializer found it empty.

The low-water mark is the queue depth shifted right by a 4-bit level field. Level 1 gives half the depth. A level large enough to shift every bit out gives a mark of zero, and the below-mark cause then never fires. Samples are either 32-bit words or 16-bit words carried in the upper half of a 32-bit slot. Back-pressure on the stream is advisory: `s_ready` is low only while the queue is full. A producer that still presents a beat at that time loses the beat, and the overflow cause is raised.

Top module: `i2s_tx_fifo`

## Requirements
- R1: After reset the configuration and status words read 0, `s_ready` is 1, and `irq`, `i2s_bclk`, `i2s_ws` and `i2s_sd` are 0.
- R2: `s_ready` is 1 whenever the queue holds fewer than DEPTH entries. A beat with `s_valid` high and `s_ready` high is stored. A beat with `s_valid` high while `s_ready` is low is discarded and sets status bit 2 (overflow).
- R3: Register address 0 is the configuration word and reads back what was written. Its fields are bit 0 transmit enable, bit 1 interrupt enable, bit 2 32-bit sample mode, and bits 6:3 level. Address 1 is the status word in bits 2:0.
- R4: Status bit 0 (below mark) is set in every cycle in which transmit is enabled and occupancy is less than DEPTH >> level. When the level is at least log2(DEPTH)+1 the mark is zero and the bit never sets.
- R5: When the serializer needs a sample while transmit is enabled and the queue is empty, it sends an all-zero slot, keeps the bit clock and word select running, and sets status bit 1 (underrun).
- R6: Writing 1 to a status bit at address 1 clears it. If a set condition holds in the same cycle, the set wins and the bit stays 1.
- R7: `irq` is 1 exactly when interrupt enable is 1 and any status bit is 1.
- R8: The bit clock has a period of 2*CLK_DIV system clocks. `i2s_ws` is low for the left slot and high for the right slot, 32 bit clocks each. `i2s_ws` and `i2s_sd` change only on a falling bit-clock edge. The MSB of a slot follows the word-select change by one bit clock. The first queue entry goes to the left slot and the next to the right slot.
- R9: In 32-bit mode the whole entry is sent MSB first. In 16-bit mode bits 15:0 of the entry are sent MSB first, followed by 16 zero bits.
- R10: A configuration write that clears transmit enable while it was set empties the queue in that cycle, and a stream beat in that same cycle is discarded. Samples not yet loaded leave as zeros without raising underrun. The serializer finishes the current frame and then holds bit clock, word select and data at 0.
- R11: While transmit is disabled the queue still accepts stream beats, so it can be filled before transmit is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample beat present |
| s_ready | output | 1 | Queue not full |
| s_data | input | 32 | Sample entry |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = configuration, 1 = status |
| reg_wdata | input | 7 | Register write data |
| reg_rdata | output | 7 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt request |
| i2s_bclk | output | 1 | Bit clock |
| i2s_ws | output | 1 | Word select (0 = left) |
| i2s_sd | output | 1 | Serial data |

## Verification
A status clear and a status set can fall in the same cycle, because the below-mark condition is re-evaluated every cycle while the clear write lands. The bench provokes this by letting the serializer pull occupancy under the mark. It then writes 1 to bit 0 while nothing refills the queue, and requires the bit to read back as 1 with `irq` still high. A clean clear is judged separately, on the overflow bit with transmit off, where no set condition can compete.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int REG_W   = 7;
  localparam int NSTAT   = 3;
  localparam int ST_LOW  = 0;
  localparam int ST_UNDR = 1;
  localparam int ST_OVFL = 2;
  localparam int SLOT_W  = 32;

  typedef struct packed {
    logic [3:0] level;
    logic       wide;
    logic       irq_en;
    logic       tx_en;
  } cfg_t;
endpackage

// File: rtl/i2s_sample_fifo.sv
module i2s_sample_fifo #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign do_push  = push && !full && !flush;
  assign do_pop   = pop && !empty && !flush;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/i2s_frame_serializer.sv
module i2s_frame_serializer #(
  parameter int CLK_DIV = 2,
  localparam int SW     = i2s_tx_pkg::SLOT_W,
  localparam int DCW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int BIW    = $clog2(2 * SW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          wide,
  input  logic          fifo_empty,
  input  logic [SW-1:0] fifo_data,
  output logic          pop,
  output logic          underrun,
  output logic          bclk,
  output logic          ws,
  output logic          sd
);
  logic           running;
  logic [DCW-1:0] div_cnt;
  logic [BIW-1:0] bit_idx, next_idx;
  logic [SW-1:0]  shreg, slot_word, fmt_word;
  logic           half_tick, fall, load, stop;

  assign half_tick = running && (div_cnt == DCW'(CLK_DIV - 1));
  assign fall      = half_tick && bclk;
  assign next_idx  = bit_idx + 1'b1;
  // a slot word is loaded one bit after the word-select edge
  assign load      = fall && ((next_idx == BIW'(1)) || (next_idx == BIW'(SW + 1)));
  assign stop      = fall && (bit_idx == '0) && !tx_en;
  assign pop       = load && tx_en && !fifo_empty;
  assign underrun  = load && tx_en && fifo_empty;

  assign fmt_word  = wide ? fifo_data : {fifo_data[SW/2-1:0], {(SW/2){1'b0}}};
  assign slot_word = pop ? fmt_word : '0;
  assign sd        = shreg[SW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      div_cnt <= '0;
      bclk    <= 1'b0;
      bit_idx <= '0;
      ws      <= 1'b0;
      shreg   <= '0;
    end else if (!running) begin
      if (tx_en) begin
        running <= 1'b1;
        div_cnt <= '0;
        bclk    <= 1'b0;
        bit_idx <= '0;
        ws      <= 1'b0;
        shreg   <= '0;
      end
    end else begin
      div_cnt <= half_tick ? '0 : div_cnt + 1'b1;
      if (stop) begin
        running <= 1'b0;
        bclk    <= 1'b0;
        bit_idx <= '0;
        ws      <= 1'b0;
        shreg   <= '0;
      end else if (half_tick) begin
        bclk <= ~bclk;
        if (fall) begin
          bit_idx <= next_idx;
          ws      <= next_idx[BIW-1];
          shreg   <= load ? slot_word : {shreg[SW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/i2s_ctrl_regs.sv
module i2s_ctrl_regs
  import i2s_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic [NSTAT-1:0] set_evt,
  output cfg_t             cfg,
  output logic [NSTAT-1:0] status,
  output logic             flush,
  output logic             irq
);
  logic [NSTAT-1:0] clr;

  assign clr   = (wr && addr) ? wdata[NSTAT-1:0] : '0;
  assign flush = wr && !addr && !wdata[0] && cfg.tx_en;
  assign irq   = cfg.irq_en && (|status);
  assign rdata = addr ? {{(REG_W-NSTAT){1'b0}}, status} : cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      status <= '0;
    end else begin
      if (wr && !addr) cfg <= cfg_t'(wdata);
      status <= (status & ~clr) | set_evt;
    end
  end
endmodule

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo
  import i2s_tx_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int CLK_DIV = 2,
  localparam int CW     = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [31:0]      s_data,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  output logic             i2s_bclk,
  output logic             i2s_ws,
  output logic             i2s_sd
);
  cfg_t             cfg;
  logic [NSTAT-1:0] status, set_evt;
  logic [CW-1:0]    fifo_count, low_mark;
  logic [31:0]      fifo_data;
  logic             fifo_full, fifo_empty, pop, under_evt, flush;
  logic             cfg_irq_en;

  assign cfg_irq_en = cfg.irq_en;
  assign s_ready    = !fifo_full;
  assign low_mark   = CW'(DEPTH) >> cfg.level;

  assign set_evt[ST_LOW]  = cfg.tx_en && (fifo_count < low_mark);
  assign set_evt[ST_UNDR] = under_evt;
  assign set_evt[ST_OVFL] = s_valid && !s_ready;

  i2s_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .set_evt(set_evt),
    .cfg(cfg), .status(status), .flush(flush), .irq(irq)
  );

  i2s_sample_fifo #(.DEPTH(DEPTH), .DW(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(s_valid), .push_data(s_data),
    .pop(pop), .pop_data(fifo_data),
    .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  i2s_frame_serializer #(.CLK_DIV(CLK_DIV)) u_ser (
    .clk(clk), .rst_n(rst_n), .tx_en(cfg.tx_en), .wide(cfg.wide),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .pop(pop), .underrun(under_evt),
    .bclk(i2s_bclk), .ws(i2s_ws), .sd(i2s_sd)
  );
endmodule

// File: rtl/i2s_tx_checker.sv
module i2s_tx_checker #(
  parameter int DEPTH = 1024,
  parameter int CW    = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          irq,
  input logic          irq_en,
  input logic          i2s_bclk,
  input logic          i2s_ws,
  input logic          i2s_sd,
  input logic [CW-1:0] count,
  input logic [2:0]    status,
  input logic          under_evt,
  input logic          flush
);
  a_r2_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> status[2]);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r5_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    under_evt |=> status[1]);
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  a_r8_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(i2s_ws) |-> $fell(i2s_bclk));
  a_r8_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(i2s_sd) |-> $fell(i2s_bclk));
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

bind i2s_tx_fifo i2s_tx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .irq(irq), .irq_en(cfg_irq_en), .i2s_bclk(i2s_bclk), .i2s_ws(i2s_ws),
  .i2s_sd(i2s_sd), .count(fifo_count), .status(status),
  .under_evt(under_evt), .flush(flush)
);

// File: tb/tb_i2s_tx_fifo.sv
`timescale 1ns/1ps
module tb_i2s_tx_fifo;
  localparam int DEPTH   = 16;
  localparam int CLK_DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [31:0] s_data = '0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [6:0] reg_wdata = '0;
  logic [6:0] reg_rdata;
  logic       irq, i2s_bclk, i2s_ws, i2s_sd;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  i2s_tx_fifo #(.DEPTH(DEPTH), .CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .i2s_bclk(i2s_bclk), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd)
  );

  // receiver model: sample on rising bit clock, a word-select change marks the LSB
  logic [31:0] cap = '0;
  logic        ws_prev = 1'b0;
  logic [31:0] words [256];
  logic        word_ws [256];
  int          nw = 0;
  always @(posedge i2s_bclk) begin
    cap <= {cap[30:0], i2s_sd};
    if (i2s_ws != ws_prev) begin
      words[nw & 255]   <= {cap[30:0], i2s_sd};
      word_ws[nw & 255] <= ws_prev;
      nw <= nw + 1;
    end
    ws_prev <= i2s_ws;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [6:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [6:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    s_valid = 1'b1; s_data = d;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_words(input int target);
    while (nw < target) @(negedge clk);
  endtask

  task automatic go_idle();
    repeat (600) @(negedge clk);
    wr_reg(1'b1, 7'h07);
  endtask

  task automatic t_reset();
    logic [6:0] r;
    rd_reg(1'b0, r); chk("R1 cfg", 32'(r), 0);
    rd_reg(1'b1, r); chk("R1 status", 32'(r), 0);
    chk("R1 s_ready", 32'(s_ready), 1);
    chk("R1 pins", {29'b0, irq, i2s_bclk, i2s_ws | i2s_sd}, 0);
  endtask

  task automatic t_stream32();
    logic [6:0] r;
    logic [31:0] v [4];
    int base;
    time t0;
    v[0] = 32'hC001_0A01; v[1] = 32'h1234_5678; v[2] = 32'hDEAD_BEEF; v[3] = 32'h0F0F_F0F0;
    wr_reg(1'b0, 7'h04);
    rd_reg(1'b0, r); chk("R3 cfg readback", 32'(r), 32'h04);
    for (int i = 0; i < 4; i++) push(v[i]);   // R11 prefill while disabled
    base = nw;
    wr_reg(1'b0, 7'h05);
    @(posedge i2s_bclk); t0 = $time;
    @(posedge i2s_bclk);
    chk("R8 bclk period", 32'($time - t0), 32'(2 * CLK_DIV * 8));
    wait_words(base + 4);
    for (int i = 0; i < 4; i++) begin
      chk("R9/R11 word32", words[(base + i) & 255], v[i]);
      chk("R8 slot order", 32'(word_ws[(base + i) & 255]), 32'(i % 2));
    end
    wait_words(base + 6);
    chk("R5 zero left", words[(base + 4) & 255], 0);
    chk("R5 zero right", words[(base + 5) & 255], 0);
    rd_reg(1'b1, r); chk("R5 underrun bit", 32'(r[1]), 1);
    chk("R7 irq masked", 32'(irq), 0);
    wr_reg(1'b0, 7'h04);
    go_idle();
    rd_reg(1'b1, r); chk("R6 clear all", 32'(r), 0);
  endtask

  task automatic t_width16();
    int base;
    wr_reg(1'b0, 7'h00);
    push(32'hAAAA_1234);
    push(32'h5555_BEEF);
    base = nw;
    wr_reg(1'b0, 7'h01);
    wait_words(base + 2);
    chk("R9 left16", words[base & 255], 32'h1234_0000);
    chk("R9 right16", words[(base + 1) & 255], 32'hBEEF_0000);
    wr_reg(1'b0, 7'h00);
    go_idle();
  endtask

  task automatic t_threshold();
    logic [6:0] r;
    int base;
    wr_reg(1'b0, 7'h12);              // level 2 -> mark 4, irq on, tx off
    for (int i = 0; i < 6; i++) push(32'h100 + 32'(i));
    rd_reg(1'b1, r); chk("R4 no mark while disabled", 32'(r), 0);
    base = nw;
    wr_reg(1'b0, 7'h13);
    wait_words(base + 2);              // occupancy 4, not below
    rd_reg(1'b1, r); chk("R4 at mark", 32'(r[0]), 0);
    chk("R7 irq low", 32'(irq), 0);
    wait_words(base + 3);              // occupancy 3, below
    rd_reg(1'b1, r); chk("R4 below mark", 32'(r[0]), 1);
    chk("R7 irq high", 32'(irq), 1);
    wr_reg(1'b1, 7'h01);               // clear collides with set
    rd_reg(1'b1, r); chk("R6 set wins", 32'(r[0]), 1);
    chk("R6 irq held", 32'(irq), 1);
    wr_reg(1'b0, 7'h12);
    go_idle();
    chk("R7 irq after clear", 32'(irq), 0);
  endtask

  task automatic t_level_zero();
    logic [6:0] r;
    int base;
    base = nw;
    wr_reg(1'b0, 7'h29);              // level 5 -> mark 0 for depth 16
    wait_words(base + 2);
    rd_reg(1'b1, r);
    chk("R4 zero mark", 32'(r[0]), 0);
    chk("R5 underrun empty", 32'(r[1]), 1);
    wr_reg(1'b0, 7'h28);
    go_idle();
  endtask

  task automatic t_overflow();
    logic [6:0] r;
    wr_reg(1'b0, 7'h02);
    for (int i = 0; i < DEPTH; i++) push(32'h200 + 32'(i));
    chk("R2 full ready low", 32'(s_ready), 0);
    rd_reg(1'b1, r); chk("R2 no overflow yet", 32'(r), 0);
    push(32'hFFFF_FFFF);
    rd_reg(1'b1, r); chk("R2 overflow bit", 32'(r), 32'h4);
    chk("R7 irq on overflow", 32'(irq), 1);
    wr_reg(1'b1, 7'h04);
    rd_reg(1'b1, r); chk("R6 w1c", 32'(r), 0);
    chk("R7 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_flush();
    logic [6:0] r;
    int base;
    logic idle_bad;
    wr_reg(1'b0, 7'h05);
    repeat (40) @(negedge clk);
    base = nw;
    wr_reg(1'b0, 7'h04);              // flush mid left slot
    wait_words(base + 2);
    chk("R10 left kept", words[base & 255], 32'h200);
    chk("R10 right zero", words[(base + 1) & 255], 0);
    rd_reg(1'b1, r); chk("R10 no underrun", 32'(r[1]), 0);
    repeat (300) @(negedge clk);
    idle_bad = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (i2s_bclk || i2s_ws || i2s_sd) idle_bad = 1'b1;
    end
    chk("R10 idle pins", 32'(idle_bad), 0);
    wr_reg(1'b1, 7'h07);
    base = nw;
    wr_reg(1'b0, 7'h05);
    wait_words(base + 2);
    chk("R10 flushed left", words[base & 255], 0);
    chk("R10 flushed right", words[(base + 1) & 255], 0);
    rd_reg(1'b1, r); chk("R5 underrun after flush", 32'(r[1]), 1);
    wr_reg(1'b0, 7'h04);
    go_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stream32();
    t_width16();
    t_threshold();
    t_level_zero();
    t_overflow();
    t_flush();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule